// File: doc/BRIEF.md
# Wide Bundle Slot Legality Gate

This block sits between the fetch of a wide instruction bundle and a row of execution units. Each bundle is 128 bits and holds one operation per slot, with four or five slots. Every slot feeds its own execution unit, and the units can do different things. For each bundle the block reads the operation class tag of every slot and checks it against that slot's capability set. It also applies the structural rule for memory stores: a store may only sit in slot 0. When the bundle passes, the block issues one valid per busy slot to the execution units.

A rejected bundle reaches no unit. Instead the block raises an illegal-instruction request for one cycle and names the slots that broke a rule. Bundles arrive on a valid/ready input. A bundle is taken on a clock edge where `bndl_valid` and `bndl_ready` are both high, and the source has to hold `bndl_data` steady until then.

On the unit side, a legal bundle stays in the dispatch register until the units raise `exec_ready`. The units see their slot valids, and the bundle stays the same until the units take it. While a bundle waits, `bndl_ready` is low. A bundle whose slots are all NOP is accepted but is never placed in the dispatch register. The combinational `bndl_legal` output gives the verdict on whatever bundle is on the input at that moment.

Top module: `vliw_slot_gate`

## Requirements
- R1: While reset is asserted, and after it, `slot_vld`, `illegal_req` and `slot_err` are all zero and `bndl_ready` is high.
- R2: Slot k occupies bundle bits [k*W +: W], with W = 128 / slot count (25 with five slots). Its class tag sits in the low three bits of that field. The codes are NOP=0, ALU=1, MAC=2, LOAD=3, STORE=4, BRANCH=5, and codes 6 and 7 are reserved. `slot_ops` presents the slot fields of the dispatched bundle at the same positions.
- R3: Each slot accepts only the classes in its capability mask. By default: slot 0 takes ALU, LOAD and STORE; slot 1 takes ALU, MAC and LOAD; slots 2 and 3 take ALU and MAC; slot 4 takes ALU and BRANCH. Reserved codes are illegal in every slot.
- R4: A STORE in any slot other than 0 flags that slot, whatever the mask says. A bundle with two or more stores is therefore illegal.
- R5: A legal bundle accepted on an edge drives `slot_vld[k]` high after that edge for each non-NOP slot k, and presents the bundle's fields on `slot_ops`.
- R6: A NOP slot is never flagged and never sets its `slot_vld`. An all-NOP bundle leaves `slot_vld` at zero and does not block the input.
- R7: An illegal bundle accepted on an edge causes three things after that edge: all `slot_vld` are low, `illegal_req` is high for that one cycle, and `slot_err[k]` is set exactly for the flagged slots. `slot_err` is zero whenever `illegal_req` is low.
- R8: While any `slot_vld` is high and `exec_ready` is low, `slot_vld` and `slot_ops` hold their values and `bndl_ready` is low. At all other times `bndl_ready` is high.
- R9: `bndl_legal` is high exactly when the bundle currently on `bndl_data` breaks no slot rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bndl_valid | input | 1 | Bundle present on the input |
| bndl_ready | output | 1 | Block can take a bundle this cycle |
| bndl_data | input | 128 | Bundle of slot fields |
| bndl_legal | output | 1 | Verdict on the bundle currently on the input |
| slot_vld | output | NUM_SLOTS | Per-unit issue valid |
| slot_ops | output | NUM_SLOTS*W | Slot fields of the dispatched bundle |
| exec_ready | input | 1 | Execution units take the dispatched bundle |
| illegal_req | output | 1 | One-cycle illegal-instruction request |
| slot_err | output | NUM_SLOTS | Slots that broke a rule in the rejected bundle |

## Verification
The assertions assume a single shared `exec_ready` for all units, and they assume that the bundle source obeys the handshake. They also rely on each slot's tag being decoded only from its own low three bits, so the payload bits may carry anything. The stimulus drives inputs only between clock edges and holds a bundle until it is taken. It mixes directed cases (store placement, double stores, reserved codes, all-NOP, back-pressure) with random bundles whose payloads are random and whose tags are weighted towards legal classes. `exec_ready` toggles at random so that stalls overlap new bundles.

// File: rtl/vliw_slot_pkg.sv
package vliw_slot_pkg;

  localparam int TAG_W   = 3;
  localparam int CLS_NUM = 1 << TAG_W;

  typedef enum logic [TAG_W-1:0] {
    CLS_NOP    = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_MAC    = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_RSV6   = 3'd6,
    CLS_RSV7   = 3'd7
  } op_class_e;

  typedef logic [CLS_NUM-1:0] cap_mask_t;

  // Bit for one class inside a capability mask.
  function automatic cap_mask_t cls_bit(input op_class_e c);
    cap_mask_t m;
    m = '0;
    m[c] = 1'b1;
    return m;
  endfunction

  // Mask as the checker applies it: NOP always allowed, reserved codes
  // never allowed, stores only where the slot index permits them.
  function automatic cap_mask_t effective_mask(input cap_mask_t raw,
                                               input bit store_ok);
    cap_mask_t m;
    m = raw | cls_bit(CLS_NOP);
    m = m & ~(cls_bit(CLS_RSV6) | cls_bit(CLS_RSV7));
    if (!store_ok) m = m & ~cls_bit(CLS_STORE);
    return m;
  endfunction

endpackage

// File: rtl/vlsc_slot_check.sv
module vlsc_slot_check
  import vliw_slot_pkg::*;
#(
  parameter int        SLOT_IDX = 0,
  parameter cap_mask_t RAW_MASK = 8'h03
) (
  input  logic [TAG_W-1:0] tag,
  output logic             bad,
  output logic             issue
);

  localparam bit        STORE_OK = (SLOT_IDX == 0);
  localparam cap_mask_t EFF_MASK = effective_mask(RAW_MASK, STORE_OK);

  op_class_e cls;

  always_comb begin
    cls   = op_class_e'(tag);
    bad   = ~EFF_MASK[cls];
    issue = (cls != CLS_NOP) && EFF_MASK[cls];
  end

endmodule

// File: rtl/vlsc_bundle_eval.sv
module vlsc_bundle_eval
  import vliw_slot_pkg::*;
#(
  parameter int                    NUM_SLOTS = 5,
  parameter int                    BUNDLE_W  = 128,
  parameter cap_mask_t [4:0]       CAP_MASK  = {8'h23, 8'h07, 8'h07, 8'h0F, 8'h1B},
  localparam int                   SLOT_W    = BUNDLE_W / NUM_SLOTS,
  localparam int                   USED_W    = SLOT_W * NUM_SLOTS
) (
  input  logic [BUNDLE_W-1:0]  bundle,
  output logic [NUM_SLOTS-1:0] bad,
  output logic [NUM_SLOTS-1:0] issue,
  output logic [USED_W-1:0]    fields,
  output logic                 ok
);

  localparam int PAD_W = BUNDLE_W - USED_W;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [SLOT_W-1:0] fld;
    assign fld = bundle[k*SLOT_W +: SLOT_W];
    assign fields[k*SLOT_W +: SLOT_W] = fld;

    vlsc_slot_check #(
      .SLOT_IDX (k),
      .RAW_MASK (CAP_MASK[k])
    ) u_chk (
      .tag   (fld[TAG_W-1:0]),
      .bad   (bad[k]),
      .issue (issue[k])
    );
  end

  if (PAD_W > 0) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^bundle[BUNDLE_W-1:USED_W];
  end

  assign ok = ~|bad;

endmodule

// File: rtl/vlsc_dispatch_stage.sv
module vlsc_dispatch_stage #(
  parameter int NUM_SLOTS = 5,
  parameter int OPS_W     = 125
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_ok,
  input  logic [NUM_SLOTS-1:0] in_issue,
  input  logic [NUM_SLOTS-1:0] in_bad,
  input  logic [OPS_W-1:0]     in_ops,
  input  logic                 exec_ready,
  output logic [NUM_SLOTS-1:0] slot_vld,
  output logic [OPS_W-1:0]     slot_ops,
  output logic                 illegal_req,
  output logic [NUM_SLOTS-1:0] slot_err
);

  logic [NUM_SLOTS-1:0] vld_q;
  logic [OPS_W-1:0]     ops_q;
  logic                 ill_q;
  logic [NUM_SLOTS-1:0] err_q;
  logic                 busy;
  logic                 take;
  logic                 take_good;
  logic                 take_bad;

  assign busy      = |vld_q;
  assign in_ready  = ~busy | exec_ready;
  assign take      = in_valid & in_ready;
  assign take_good = take & in_ok & (|in_issue);
  assign take_bad  = take & ~in_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ops_q <= '0;
      ill_q <= 1'b0;
      err_q <= '0;
    end else begin
      ill_q <= take_bad;
      err_q <= take_bad ? in_bad : '0;
      if (take_good) begin
        vld_q <= in_issue;
        ops_q <= in_ops;
      end else if (exec_ready) begin
        vld_q <= '0;
      end
    end
  end

  assign slot_vld    = vld_q;
  assign slot_ops    = ops_q;
  assign illegal_req = ill_q;
  assign slot_err    = err_q;

endmodule

// File: rtl/vliw_slot_gate.sv
module vliw_slot_gate
  import vliw_slot_pkg::*;
#(
  parameter int              NUM_SLOTS = 5,
  parameter int              BUNDLE_W  = 128,
  parameter cap_mask_t [4:0] CAP_MASK  = {8'h23, 8'h07, 8'h07, 8'h0F, 8'h1B},
  localparam int             SLOT_W    = BUNDLE_W / NUM_SLOTS,
  localparam int             OPS_W     = SLOT_W * NUM_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bndl_valid,
  output logic                 bndl_ready,
  input  logic [BUNDLE_W-1:0]  bndl_data,
  output logic                 bndl_legal,
  output logic [NUM_SLOTS-1:0] slot_vld,
  output logic [OPS_W-1:0]     slot_ops,
  input  logic                 exec_ready,
  output logic                 illegal_req,
  output logic [NUM_SLOTS-1:0] slot_err
);

  logic [NUM_SLOTS-1:0] ev_bad;
  logic [NUM_SLOTS-1:0] ev_issue;
  logic [OPS_W-1:0]     ev_fields;
  logic                 ev_ok;

  vlsc_bundle_eval #(
    .NUM_SLOTS (NUM_SLOTS),
    .BUNDLE_W  (BUNDLE_W),
    .CAP_MASK  (CAP_MASK)
  ) u_eval (
    .bundle (bndl_data),
    .bad    (ev_bad),
    .issue  (ev_issue),
    .fields (ev_fields),
    .ok     (ev_ok)
  );

  vlsc_dispatch_stage #(
    .NUM_SLOTS (NUM_SLOTS),
    .OPS_W     (OPS_W)
  ) u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (bndl_valid),
    .in_ready    (bndl_ready),
    .in_ok       (ev_ok),
    .in_issue    (ev_issue),
    .in_bad      (ev_bad),
    .in_ops      (ev_fields),
    .exec_ready  (exec_ready),
    .slot_vld    (slot_vld),
    .slot_ops    (slot_ops),
    .illegal_req (illegal_req),
    .slot_err    (slot_err)
  );

  assign bndl_legal = ev_ok;

endmodule

// File: rtl/vliw_slot_gate_chk.sv
module vliw_slot_gate_chk
  import vliw_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int BUNDLE_W  = 128,
  localparam int SLOT_W   = BUNDLE_W / NUM_SLOTS,
  localparam int OPS_W    = SLOT_W * NUM_SLOTS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 exec_ready,
  input logic                 bndl_ready,
  input logic [NUM_SLOTS-1:0] slot_vld,
  input logic [OPS_W-1:0]     slot_ops,
  input logic                 illegal_req,
  input logic [NUM_SLOTS-1:0] slot_err
);

  // R7: a rejected bundle never reaches a unit
  a_r7_no_issue_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req |-> (slot_vld == '0));

  // R7: error flags only accompany the request, and the request names a slot
  a_r7_err_only_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_req |-> (slot_err == '0));

  a_r7_req_names_slot: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req |-> (slot_err != '0));

  // R8: a stalled dispatch holds and blocks the input
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slot_vld) && !exec_ready) |=> ($stable(slot_vld) && $stable(slot_ops)));

  a_r8_block_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slot_vld) && !exec_ready) |-> !bndl_ready);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    // R6: an issued slot never carries a NOP
    a_r6_no_nop_issue: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[k] |-> (slot_ops[k*SLOT_W +: TAG_W] != CLS_NOP));

    if (k > 0) begin : g_nz
      // R4: stores reach only slot 0
      a_r4_store_slot0_only: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[k] |-> (slot_ops[k*SLOT_W +: TAG_W] != CLS_STORE));
    end
  end

endmodule

bind vliw_slot_gate vliw_slot_gate_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .BUNDLE_W  (BUNDLE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .exec_ready  (exec_ready),
  .bndl_ready  (bndl_ready),
  .slot_vld    (slot_vld),
  .slot_ops    (slot_ops),
  .illegal_req (illegal_req),
  .slot_err    (slot_err)
);

// File: tb/vliw_slot_gate_tb_top.sv
`timescale 1ns/1ps
module vliw_slot_gate_tb_top;

  localparam int NS = 5;
  localparam int SW = 25;
  localparam int OW = NS * SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bndl_valid = 1'b0;
  logic          bndl_ready;
  logic [127:0]  bndl_data = '0;
  logic          bndl_legal;
  logic [NS-1:0] slot_vld;
  logic [OW-1:0] slot_ops;
  logic          exec_ready = 1'b0;
  logic          illegal_req;
  logic [NS-1:0] slot_err;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #4 clk = ~clk;

  vliw_slot_gate dut_i (
    .clk(clk), .rst_n(rst_n), .bndl_valid(bndl_valid), .bndl_ready(bndl_ready),
    .bndl_data(bndl_data), .bndl_legal(bndl_legal), .slot_vld(slot_vld),
    .slot_ops(slot_ops), .exec_ready(exec_ready), .illegal_req(illegal_req),
    .slot_err(slot_err)
  );

  // Capability table written from the requirements (R3, R4).
  function automatic bit allowed(input int slot, input int cls);
    case (cls)
      0: return 1'b1;
      1: return 1'b1;
      2: return (slot >= 1) && (slot <= 3);
      3: return (slot == 0) || (slot == 1);
      4: return (slot == 0);
      5: return (slot == 4);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tag_of(input logic [127:0] b, input int s);
    return int'(b[s*SW +: 3]);
  endfunction

  function automatic logic [NS-1:0] bad_of(input logic [127:0] b);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) r[s] = !allowed(s, tag_of(b, s));
    return r;
  endfunction

  function automatic logic [NS-1:0] issue_of(input logic [127:0] b);
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) r[s] = (tag_of(b, s) != 0) && allowed(s, tag_of(b, s));
    return r;
  endfunction

  function automatic logic [127:0] mk(input int c0, input int c1, input int c2,
                                      input int c3, input int c4, input logic [21:0] pl);
    logic [127:0] b;
    int cs[NS];
    cs = '{c0, c1, c2, c3, c4};
    b = '0;
    for (int s = 0; s < NS; s++) b[s*SW +: SW] = {pl ^ 22'(s * 7919), 3'(cs[s])};
    b[127:125] = pl[2:0];
    return b;
  endfunction

  // Reference model state
  logic [NS-1:0] m_vld = '0;
  logic [OW-1:0] m_ops = '0;
  logic          m_ill = 1'b0;
  logic [NS-1:0] m_err = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = '0; m_ops = '0; m_ill = 1'b0; m_err = '0;
    end else begin
      bit rdy, acc, good;
      rdy  = (m_vld == '0) || exec_ready;
      acc  = bndl_valid && rdy;
      good = (bad_of(bndl_data) == '0);
      m_ill = acc && !good;
      m_err = (acc && !good) ? bad_of(bndl_data) : '0;
      if (acc && good && (issue_of(bndl_data) != '0)) begin
        m_vld = issue_of(bndl_data);
        m_ops = bndl_data[OW-1:0];
      end else if (exec_ready) begin
        m_vld = '0;
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R5 R6 slot_vld", 128'(slot_vld), 128'(m_vld));
      if (m_vld != '0) chk("R2 R5 slot_ops", 128'(slot_ops), 128'(m_ops));
      chk("R7 illegal_req", 128'(illegal_req), 128'(m_ill));
      chk("R4 R7 slot_err", 128'(slot_err), 128'(m_err));
      chk("R8 bndl_ready", 128'(bndl_ready), 128'((m_vld == '0) || exec_ready));
      chk("R3 R4 R9 bndl_legal", 128'(bndl_legal), 128'(bad_of(bndl_data) == '0));
    end
  end

  task automatic drive(input logic v, input logic [127:0] d, input logic er);
    @(negedge clk);
    #1;
    bndl_valid = v;
    bndl_data  = d;
    exec_ready = er;
  endtask

  task automatic random_bundle(output logic [127:0] b);
    int cs[NS];
    for (int s = 0; s < NS; s++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 12) begin
        int tries;
        tries = 0;
        cs[s] = $urandom_range(0, 5);
        while (!allowed(s, cs[s]) && tries < 8) begin
          cs[s] = $urandom_range(0, 5);
          tries++;
        end
      end else begin
        cs[s] = $urandom_range(0, 7);
      end
    end
    b = mk(cs[0], cs[1], cs[2], cs[3], cs[4], 22'($urandom));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] b;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 slot_vld", 128'(slot_vld), 128'(0));
    chk("R1 illegal_req", 128'(illegal_req), 128'(0));
    chk("R1 slot_err", 128'(slot_err), 128'(0));
    chk("R1 bndl_ready", 128'(bndl_ready), 128'(1));
    #1 rst_n = 1'b1;
    run_cmp = 1'b1;
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b1);
    // R1 after reset release
    chk("R1 idle slot_vld", 128'(slot_vld), 128'(0));

    // R6: all NOP bundle
    drive(1'b1, mk(0, 0, 0, 0, 0, 22'h1234), 1'b0);
    drive(1'b0, '0, 1'b0);
    chk("R6 all-NOP no issue", 128'(slot_vld), 128'(0));
    chk("R6 all-NOP ready", 128'(bndl_ready), 128'(1));
    // R5: full legal bundle
    drive(1'b1, mk(4, 2, 1, 2, 5, 22'h2aaaa), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R5 full bundle issue", 128'(slot_vld), 128'(5'b11111));
    // R4: store in slot 2
    drive(1'b1, mk(1, 1, 4, 1, 1, 22'h00f0f), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R4 store slot2 flagged", 128'(slot_err), 128'(5'b00100));
    chk("R7 reject request", 128'(illegal_req), 128'(1));
    drive(1'b0, '0, 1'b1);
    chk("R7 request one cycle", 128'(illegal_req), 128'(0));
    // R4: two stores
    drive(1'b1, mk(4, 4, 0, 0, 0, 22'h3c3c3), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R4 double store", 128'(slot_err), 128'(5'b00010));
    // R3: MAC in slot 0, BRANCH in slot 1, reserved in slot 3
    drive(1'b1, mk(2, 5, 1, 6, 3, 22'h15555), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R3 capability flags", 128'(slot_err), 128'(5'b11011));
    chk("R7 no issue on reject", 128'(slot_vld), 128'(0));
    // R8: back-pressure
    drive(1'b1, mk(3, 3, 2, 0, 1, 22'h0beef), 1'b0);
    drive(1'b1, mk(1, 0, 0, 0, 0, 22'h00001), 1'b0);
    drive(1'b1, mk(1, 0, 0, 0, 0, 22'h00001), 1'b0);
    chk("R8 stalled hold", 128'(slot_vld), 128'(5'b10111));
    chk("R8 stalled ready low", 128'(bndl_ready), 128'(0));
    drive(1'b1, mk(1, 0, 0, 0, 0, 22'h00001), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R8 next bundle after release", 128'(slot_vld), 128'(5'b00001));
    // R7: back-to-back rejects
    drive(1'b1, mk(0, 0, 0, 0, 4, 22'h0), 1'b1);
    drive(1'b1, mk(0, 0, 0, 7, 0, 22'h0), 1'b1);
    drive(1'b0, '0, 1'b1);
    chk("R7 second reject flags", 128'(slot_err), 128'(5'b01000));

    // Random traffic with random stalls
    for (int i = 0; i < 4000; i++) begin
      random_bundle(b);
      drive(($urandom_range(0, 3) != 0), b, ($urandom_range(0, 2) != 0));
      // hold a waiting bundle until accepted
      while (bndl_valid && !bndl_ready) drive(1'b1, b, ($urandom_range(0, 2) != 0));
    end
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b1);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule